// File: doc/BRIEF.md
# Sequenced-Read Packet Statistics Bank

This block holds packet statistics for a physical-layer management space. Two independent groups, transmit and receive, each keep a 32-bit good-packet count and a 16-bit error-packet count. A per-direction event strobe marks one packet, and a companion error flag says which counter it bumps. Software reads each group through three 16-bit registers. Reading the first register of a group freezes that group, so that the low and high halves of the packet count stay coherent. Only a clean read of the three registers in ascending order clears the group.

While a group is frozen, new events collect in a shadow accumulator. A clear moves the shadow into the live counters. A broken sequence folds the shadow back into the live counters without clearing them, so no event is lost either way. A separate status register carries a saturating 6-bit link-loss counter in its top bits, and reading that register clears the counter.

Top module: `pkt_stat_bank`

## Requirements
- R1: After reset, every register in the bank reads zero.
- R2: Read data is registered and appears on `rd_data_o` one clock after the read strobe. Offset 0 returns transmit packet count bits 15:0, offset 1 returns bits 31:16, and offset 2 returns the transmit error count. Offsets 3, 4 and 5 return the same three fields for receive.
- R3: A strobe with its error flag low increments the good-packet count only. A strobe with the flag high increments the error count only.
- R4: A read of a group's first register freezes that group's visible values. Events that arrive afterwards are not visible until the group leaves the frozen state.
- R5: A read of the group's offsets in the order first, second, third clears the group. The live counts then equal the events that arrived while the group was frozen.
- R6: Any other read of the group while it is frozen breaks the sequence. The group returns to idle without clearing, and the events held during the freeze are added to the live counts. Reads of the second or third register while idle have no effect.
- R7: Reads of one group, or of any other offset, leave the other group's sequence state unchanged.
- R8: All counters saturate at their maximum value and never wrap.
- R9: Offset 7 returns the link-loss count in bits 15:10 and zeros in bits 9:0. The count saturates at 63.
- R10: A read of offset 7 clears the link-loss count. A loss event in the same cycle leaves the count at 1.
- R11: Offset 6 and offsets 8 to 15 read zero and do not disturb either group's sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_pkt_i | input | 1 | Transmit packet event strobe |
| tx_err_i | input | 1 | Transmit packet had an error (qualifies tx_pkt_i) |
| rx_pkt_i | input | 1 | Receive packet event strobe |
| rx_err_i | input | 1 | Receive packet had an error (qualifies rx_pkt_i) |
| link_loss_i | input | 1 | Link-loss event strobe |
| rd_valid_i | input | 1 | Register read strobe |
| rd_addr_i | input | 4 | Register offset |
| rd_data_o | output | 16 | Registered read data |

## Verification
On every cycle, the assertions check four things. A frozen group's live counters do not move. The shadow is empty whenever a group is idle. A tracker never changes state without a read of its own group. Counters stay at their maximum once they reach it. The assertions also cover the link-loss clear rule and the zero returned for unmapped offsets. Other behaviour can only be shown by the bench's read sequences: that a broken order leaves the group uncleared with the held events merged in, that interleaved reads of the other group or of unmapped offsets still let a clean sequence clear, and the values each register returns.

// File: rtl/pkt_stat_pkg.sv
package pkt_stat_pkg;
  localparam int NUM_GRP  = 2;
  localparam int GRP_REGS = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LO   = 2'd1,
    SEQ_HI   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pkt_stat_loss.sv
module pkt_stat_loss #(
  parameter int LOSS_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              loss_i,
  input  logic              clr_i,
  output logic [LOSS_W-1:0] cnt_o
);
  logic [LOSS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= LOSS_W'(loss_i);
    else if (loss_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_loss_sat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1 && !clr_i) |=> cnt_q == '1);
  assert_loss_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !loss_i) |=> cnt_q == '0);
  assert_loss_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && loss_i) |=> cnt_q == LOSS_W'(1));
endmodule

// File: rtl/pkt_stat_group.sv
module pkt_stat_group
  import pkt_stat_pkg::*;
#(
  parameter int PKT_W = 32,
  parameter int ERR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             good_i,
  input  logic             bad_i,
  input  logic             rd_hit_i,
  input  logic [1:0]       rd_idx_i,
  output logic [PKT_W-1:0] pkt_cnt_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  seq_state_e       state_q;
  logic [PKT_W-1:0] pkt_q, shd_pkt_q, shd_pkt_inc;
  logic [ERR_W-1:0] err_q, shd_err_q, shd_err_inc;
  logic rd_first, rd_second, rd_third;
  logic freeze_start, do_clear, do_break;

  function automatic logic [PKT_W-1:0] sat_pkt(input logic [PKT_W-1:0] a, input logic [PKT_W-1:0] b);
    logic [PKT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[PKT_W] ? '1 : s[PKT_W-1:0];
  endfunction

  function automatic logic [ERR_W-1:0] sat_err(input logic [ERR_W-1:0] a, input logic [ERR_W-1:0] b);
    logic [ERR_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ERR_W] ? '1 : s[ERR_W-1:0];
  endfunction

  always_comb begin
    rd_first     = rd_hit_i && rd_idx_i == 2'd0;
    rd_second    = rd_hit_i && rd_idx_i == 2'd1;
    rd_third     = rd_hit_i && rd_idx_i == 2'd2;
    freeze_start = state_q == SEQ_IDLE && rd_first;
    do_clear     = state_q == SEQ_HI && rd_third;
    // any own-group read in a frozen state that is not the next step
    do_break     = state_q != SEQ_IDLE && (rd_first || rd_second || rd_third)
                   && !(state_q == SEQ_LO && rd_second) && !do_clear;
    shd_pkt_inc  = sat_pkt(shd_pkt_q, PKT_W'(good_i));
    shd_err_inc  = sat_err(shd_err_q, ERR_W'(bad_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      pkt_q     <= '0;
      err_q     <= '0;
      shd_pkt_q <= '0;
      shd_err_q <= '0;
    end else if (state_q == SEQ_IDLE) begin
      if (freeze_start) begin
        state_q   <= SEQ_LO;
        shd_pkt_q <= PKT_W'(good_i);
        shd_err_q <= ERR_W'(bad_i);
      end else begin
        pkt_q <= sat_pkt(pkt_q, PKT_W'(good_i));
        err_q <= sat_err(err_q, ERR_W'(bad_i));
      end
    end else if (do_clear) begin
      state_q   <= SEQ_IDLE;
      pkt_q     <= shd_pkt_inc;
      err_q     <= shd_err_inc;
      shd_pkt_q <= '0;
      shd_err_q <= '0;
    end else if (do_break) begin
      state_q   <= SEQ_IDLE;
      pkt_q     <= sat_pkt(pkt_q, shd_pkt_inc);
      err_q     <= sat_err(err_q, shd_err_inc);
      shd_pkt_q <= '0;
      shd_err_q <= '0;
    end else begin
      shd_pkt_q <= shd_pkt_inc;
      shd_err_q <= shd_err_inc;
      if (state_q == SEQ_LO && rd_second) state_q <= SEQ_HI;
    end
  end

  assign pkt_cnt_o = pkt_q;
  assign err_cnt_o = err_q;

  assert_frozen_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SEQ_IDLE && !rd_hit_i) |=> ($stable(pkt_q) && $stable(err_q)));
  assert_clear_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_HI && rd_third) |=> (state_q == SEQ_IDLE && shd_pkt_q == '0 && shd_err_q == '0));
  assert_idle_shadow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE) |-> (shd_pkt_q == '0 && shd_err_q == '0));
  assert_seq_isolated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit_i |=> state_q == $past(state_q));
  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_q == '1 && state_q == SEQ_IDLE) |=> pkt_q == '1);
  assert_err_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q == '1 && state_q == SEQ_IDLE) |=> err_q == '1);
endmodule

// File: rtl/pkt_stat_bank.sv
module pkt_stat_bank
  import pkt_stat_pkg::*;
#(
  parameter int PKT_W    = 32,
  parameter int ERR_W    = 16,
  parameter int REG_W    = 16,
  parameter int LOSS_W   = 6,
  parameter int ADDR_W   = 4,
  parameter int LOSS_OFS = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_pkt_i,
  input  logic              tx_err_i,
  input  logic              rx_pkt_i,
  input  logic              rx_err_i,
  input  logic              link_loss_i,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o
);
  localparam int LOSS_LSB = REG_W - LOSS_W;
  localparam logic [ADDR_W-1:0] LOSS_ADDR = ADDR_W'(LOSS_OFS);

  logic [NUM_GRP-1:0] evt, evt_err, grp_hit;
  logic [ADDR_W-1:0]  grp_off [NUM_GRP];
  logic [PKT_W-1:0]   grp_pkt [NUM_GRP];
  logic [ERR_W-1:0]   grp_err [NUM_GRP];
  logic [LOSS_W-1:0]  loss_cnt;
  logic               loss_hit, rd_mapped;
  logic [REG_W-1:0]   rd_data_d, rd_data_q;

  assign evt     = {rx_pkt_i, tx_pkt_i};
  assign evt_err = {rx_err_i, tx_err_i};

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] GBASE = ADDR_W'(g * GRP_REGS);
    assign grp_off[g] = rd_addr_i - GBASE;  // wraps high below base
    assign grp_hit[g] = rd_valid_i && grp_off[g] < ADDR_W'(GRP_REGS);

    pkt_stat_group #(.PKT_W(PKT_W), .ERR_W(ERR_W)) u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .good_i   (evt[g] && !evt_err[g]),
      .bad_i    (evt[g] && evt_err[g]),
      .rd_hit_i (grp_hit[g]),
      .rd_idx_i (grp_off[g][1:0]),
      .pkt_cnt_o(grp_pkt[g]),
      .err_cnt_o(grp_err[g])
    );
  end

  assign loss_hit  = rd_valid_i && rd_addr_i == LOSS_ADDR;
  assign rd_mapped = (|grp_hit) || loss_hit;

  pkt_stat_loss #(.LOSS_W(LOSS_W)) u_loss (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .loss_i(link_loss_i),
    .clr_i (loss_hit),
    .cnt_o (loss_cnt)
  );

  always_comb begin
    rd_data_d = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (grp_hit[g]) begin
        case (grp_off[g][1:0])
          2'd0:    rd_data_d = grp_pkt[g][REG_W-1:0];
          2'd1:    rd_data_d = grp_pkt[g][PKT_W-1 -: REG_W];
          default: rd_data_d = REG_W'(grp_err[g]);
        endcase
      end
    end
    if (loss_hit) rd_data_d = {loss_cnt, {LOSS_LSB{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rd_data_q <= '0;
    else if (rd_valid_i) rd_data_q <= rd_data_d;
  end

  assign rd_data_o = rd_data_q;

  assert_unmapped_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && !rd_mapped) |=> rd_data_o == '0);
  assert_loss_low_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_hit |=> rd_data_o[LOSS_LSB-1:0] == '0);
endmodule

// File: tb/pkt_stat_bank_tb_top.sv
module pkt_stat_bank_tb_top;
  localparam logic [2:0] RD = 3'd0, TXG = 3'd1, TXE = 3'd2, RXG = 3'd3, RXE = 3'd4, LS = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  addr;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 76;
  localparam vec_t VEC [NV] = '{
    // R1 reset values
    '{RD,4'd0,16'h0,4'd1}, '{RD,4'd1,16'h0,4'd1}, '{RD,4'd2,16'h0,4'd1},
    '{RD,4'd3,16'h0,4'd1}, '{RD,4'd4,16'h0,4'd1}, '{RD,4'd5,16'h0,4'd1},
    '{RD,4'd7,16'h0,4'd1},
    // R11 unmapped
    '{RD,4'd6,16'h0,4'd11}, '{RD,4'd15,16'h0,4'd11},
    // stimulus, R3
    '{TXG,4'd0,16'h0,4'd3}, '{TXG,4'd0,16'h0,4'd3}, '{TXG,4'd0,16'h0,4'd3},
    '{TXE,4'd0,16'h0,4'd3}, '{RXG,4'd0,16'h0,4'd3}, '{RXG,4'd0,16'h0,4'd3},
    '{RXE,4'd0,16'h0,4'd3}, '{RXE,4'd0,16'h0,4'd3}, '{LS,4'd0,16'h0,4'd9},
    '{LS,4'd0,16'h0,4'd9},
    // R9 then R10
    '{RD,4'd7,16'h0800,4'd9}, '{RD,4'd7,16'h0,4'd10},
    // R2, R4 freeze with events held; R5 clears
    '{RD,4'd0,16'd3,4'd2}, '{TXG,4'd0,16'h0,4'd4}, '{TXG,4'd0,16'h0,4'd4},
    '{TXE,4'd0,16'h0,4'd4}, '{RD,4'd1,16'd0,4'd2}, '{RD,4'd2,16'd1,4'd4},
    '{RD,4'd0,16'd2,4'd5}, '{RD,4'd1,16'd0,4'd5}, '{RD,4'd2,16'd1,4'd5},
    // R7 interleaved groups
    '{RD,4'd3,16'd2,4'd2}, '{RD,4'd0,16'd0,4'd7}, '{RD,4'd4,16'd0,4'd7},
    '{RD,4'd5,16'd2,4'd7}, '{RD,4'd1,16'd0,4'd7}, '{RD,4'd2,16'd0,4'd7},
    // R11 unmapped reads inside a sequence
    '{RXG,4'd0,16'h0,4'd11}, '{RD,4'd3,16'd1,4'd2}, '{RD,4'd6,16'd0,4'd11},
    '{RD,4'd4,16'd0,4'd11}, '{RD,4'd9,16'd0,4'd11}, '{RD,4'd5,16'd0,4'd11},
    '{RD,4'd3,16'd0,4'd11}, '{RD,4'd4,16'd0,4'd11}, '{RD,4'd5,16'd0,4'd11},
    // R6 broken order 0,1,0 then no clear
    '{TXG,4'd0,16'h0,4'd6}, '{TXG,4'd0,16'h0,4'd6}, '{RD,4'd0,16'd2,4'd6},
    '{RD,4'd1,16'd0,4'd6}, '{TXG,4'd0,16'h0,4'd6}, '{RD,4'd0,16'd2,4'd6},
    '{RD,4'd1,16'd0,4'd6}, '{RD,4'd2,16'd0,4'd6}, '{RD,4'd0,16'd3,4'd6},
    '{RD,4'd1,16'd0,4'd6}, '{RD,4'd2,16'd0,4'd6}, '{RD,4'd0,16'd0,4'd6},
    '{RD,4'd1,16'd0,4'd6}, '{RD,4'd2,16'd0,4'd6},
    // R6 broken order 0,2
    '{TXE,4'd0,16'h0,4'd6}, '{RD,4'd0,16'd0,4'd6}, '{RD,4'd2,16'd1,4'd6},
    '{RD,4'd0,16'd0,4'd6}, '{RD,4'd1,16'd0,4'd6}, '{RD,4'd2,16'd1,4'd6},
    '{RD,4'd2,16'd0,4'd6},
    // R3 good and error split
    '{TXE,4'd0,16'h0,4'd3}, '{TXE,4'd0,16'h0,4'd3}, '{TXG,4'd0,16'h0,4'd3},
    '{RXG,4'd0,16'h0,4'd3}, '{RD,4'd0,16'd1,4'd3}, '{RD,4'd1,16'd0,4'd3},
    '{RD,4'd2,16'd2,4'd3}, '{RD,4'd3,16'd1,4'd3}, '{RD,4'd4,16'd0,4'd3},
    '{RD,4'd5,16'd0,4'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_pkt = 0, tx_err = 0, rx_pkt = 0, rx_err = 0, loss = 0, rd_v = 0;
  logic [3:0]  rd_a = '0;
  logic [15:0] rd_d;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pkt_stat_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_pkt_i(tx_pkt), .tx_err_i(tx_err),
    .rx_pkt_i(rx_pkt), .rx_err_i(rx_err), .link_loss_i(loss),
    .rd_valid_i(rd_v), .rd_addr_i(rd_a), .rd_data_o(rd_d)
  );

  // called at a negedge; returns at the next negedge
  task automatic step(input logic [2:0] op, input logic [3:0] a, input logic also_loss);
    tx_pkt = (op == TXG || op == TXE);
    tx_err = (op == TXE);
    rx_pkt = (op == RXG || op == RXE);
    rx_err = (op == RXE);
    loss   = (op == LS) || also_loss;
    rd_v   = (op == RD);
    rd_a   = a;
    @(negedge clk);
    {tx_pkt, tx_err, rx_pkt, rx_err, loss, rd_v} = '0;
  endtask

  task automatic check(input logic [15:0] exp, input int req);
    n_chk++;
    if (rd_d !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %h expected %h", req, rd_d, exp);
    end
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [15:0] exp, input int req);
    step(RD, a, 1'b0);
    check(exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].op, VEC[i].addr, 1'b0);
      if (VEC[i].op == RD) check(VEC[i].exp, int'(VEC[i].req));
    end

    // R9 link-loss saturates at 63 (also R8)
    loss = 1'b1;
    repeat (70) @(negedge clk);
    loss = 1'b0;
    rd_chk(4'd7, 16'hFC00, 9);
    // R10 loss in the same cycle as the read survives as 1
    repeat (3) step(LS, 4'd0, 1'b0);
    step(RD, 4'd7, 1'b1);
    check(16'h0C00, 10);
    rd_chk(4'd7, 16'h0400, 10);

    // R8 error count saturates at 16'hFFFF
    tx_pkt = 1'b1; tx_err = 1'b1;
    repeat (65540) @(negedge clk);
    tx_pkt = 1'b0; tx_err = 1'b0;
    rd_chk(4'd2, 16'hFFFF, 8);
    rd_chk(4'd0, 16'h0000, 8);
    rd_chk(4'd1, 16'h0000, 8);
    rd_chk(4'd2, 16'hFFFF, 8);
    rd_chk(4'd2, 16'h0000, 8);

    // R1 reset mid-run
    repeat (4) step(RXG, 4'd0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk(4'd3, 16'h0000, 1);
    rd_chk(4'd4, 16'h0000, 1);
    rd_chk(4'd5, 16'h0000, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule